// File: doc/BRIEF.md
# Synchronous Half-Duplex Shift Port

This block moves one byte at a time over a two-wire synchronous serial link at a fixed rate of one bit per machine cycle. The host either writes a byte to start sending it or raises a receive-enable level to start clocking a byte in. The port always drives the shift clock. During a transmission it also drives the data line. During a reception it samples the data line. Only one direction is active at any moment.

A free-running sequencer divides the clock into 12-clock machine cycles. Each cycle has six states, numbered 1 to 6, with two phases each, so slot index = (state-1)*2 + (phase-1). Every action is pinned to one slot. An action "at slot k" takes effect on the clock edge that ends slot k. Completion is not counted. It is detected from a marker bit that was preloaded into the shift register. Each direction sets a done flag, and that flag stays set until the host clears it with a one-clock pulse.

Top module: `sync_shift_port`

## Requirements
- R1: A machine cycle is 12 clocks. While a transfer is active, `shift_clk` is low in slots 4 to 9 and high in slots 10, 11, 0 to 3. Data moves one bit per machine cycle.
- R2: After reset, and whenever no transfer is active, `shift_clk` = 1, `ser_dout` = 1 and `ser_doe` = 0. Both done flags reset to 0.
- R3: A `buf_wr` pulse taken in machine cycle 0 before slot 11 commits the byte at slot 11 of that cycle. During cycle 1 the line stays idle. From slot 1 of cycle 2, `ser_doe` = 1 and `ser_dout` presents bit k of the byte during cycle 2+k, least significant bit first.
- R4: After a transmission committed in cycle 0, `tx_done` is still 0 in slot 0 of cycle 10. From slot 1 of cycle 10, `tx_done` = 1 and `ser_doe` = 0.
- R5: A reception starts when `rx_en` = 1, `rx_done` = 0 and the port is idle at slot 11 of cycle 0. The shift clock runs from cycle 2 through cycle 9.
- R6: Bit k of the received byte is the value of `ser_din` at slot 9 of cycle 2+k, least significant bit first. From slot 1 of cycle 10, `rx_done` = 1 and `rx_byte` holds the byte (bit 0 = first bit received).
- R7: While `rx_done` = 1, `rx_en` = 1 starts no reception and the shift clock stays high.
- R8: A `buf_wr` that arrives while a transmission or reception is in progress is ignored. The bits already being sent are unchanged, and no further transfer follows.
- R9: Each done flag stays at 1 until its clear input (`tx_clr` or `rx_clr`) is pulsed. The flag reads 0 in the clock after the pulse.
- R10: `ser_doe` stays 0 throughout a reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_wr | input | 1 | One-clock write strobe for the transmit byte |
| buf_wdata | input | 8 | Byte to transmit |
| rx_en | input | 1 | Receive enable level |
| tx_clr | input | 1 | Clear pulse for tx_done |
| rx_clr | input | 1 | Clear pulse for rx_done |
| ser_din | input | 1 | Serial data line input |
| ser_dout | output | 1 | Serial data line output value |
| ser_doe | output | 1 | Serial data line output enable |
| shift_clk | output | 1 | Shift clock line |
| rx_byte | output | 8 | Last received byte |
| tx_done | output | 1 | Transmit done flag |
| rx_done | output | 1 | Receive done flag |

## Verification
The bench checks the exact slot where each done flag rises, reading it one slot early and one slot on time. A design that stops the marker one shift too early or too late would move the flag by a whole machine cycle. Every transmitted bit is checked against the bit it should carry in its cycle, and every received byte against the pattern driven into it; this catches a one-cycle gap that is missing or added, and a reversed bit order. Writes are issued in the middle of a transmission and in the middle of a reception. A design that did not ignore them would corrupt the outgoing bits or start a second transfer. Receive-enable is held high with the done flag still set. A design that did not block on the flag would start clocking again.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int STATES = 6;
  localparam int PHASES = 2;
  localparam int SLOTS  = STATES * PHASES;
  localparam int CNT_W  = $clog2(SLOTS);

  function automatic int slot_of(input int st, input int ph);
    return (st - 1) * PHASES + (ph - 1);
  endfunction

  localparam int SL_S1P1 = slot_of(1, 1);
  localparam int SL_S3P1 = slot_of(3, 1);
  localparam int SL_S5P2 = slot_of(5, 2);
  localparam int SL_S6P1 = slot_of(6, 1);
  localparam int SL_S6P2 = slot_of(6, 2);

  typedef enum logic [2:0] {
    TX_IDLE, TX_HOLD, TX_GAP, TX_SEND, TX_LAST
  } tx_st_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_ARM, RX_LOAD, RX_RECV, RX_LAST
  } rx_st_e;
endpackage

// File: rtl/ssp_seq.sv
module ssp_seq
  import ssp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] slot,
  output logic             at_s1p1,
  output logic             at_s5p2,
  output logic             at_s6p2,
  output logic             clk_low
);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(SLOTS - 1);

  logic [CNT_W-1:0] slot_n;

  always_comb begin
    slot_n = (slot == LAST_SLOT) ? '0 : slot + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot <= '0;
    else        slot <= slot_n;
  end

  assign at_s1p1 = (slot == CNT_W'(SL_S1P1));
  assign at_s5p2 = (slot == CNT_W'(SL_S5P2));
  assign at_s6p2 = (slot == CNT_W'(SL_S6P2));
  assign clk_low = (slot >= CNT_W'(SL_S3P1)) && (slot < CNT_W'(SL_S6P1));
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx
  import ssp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          at_s1p1,
  input  logic          at_s6p2,
  input  logic          wr_take,
  input  logic [DW-1:0] wr_data,
  output logic          busy,
  output logic          drive,
  output logic          bit_out,
  output logic          done_set
);
  localparam logic [DW-1:0] MARK = DW'(1);

  tx_st_e        st, st_n;
  logic [DW:0]   sr, sr_n;
  logic [DW-1:0] hold, hold_n;
  logic          pend, pend_n;

  always_comb begin
    st_n     = st;
    sr_n     = sr;
    hold_n   = hold;
    pend_n   = pend;
    done_set = 1'b0;
    if (wr_take) begin
      pend_n = 1'b1;
      hold_n = wr_data;
    end
    case (st)
      TX_IDLE: if (pend && at_s6p2) begin
        sr_n   = {1'b1, hold};
        pend_n = 1'b0;
        st_n   = TX_HOLD;
      end
      TX_HOLD: if (at_s1p1) st_n = TX_GAP;
      TX_GAP:  if (at_s1p1) st_n = TX_SEND;
      TX_SEND: if (at_s6p2) begin
        sr_n = {1'b0, sr[DW:1]};
        if (sr[DW:1] == MARK) st_n = TX_LAST;
      end
      TX_LAST: if (at_s1p1) begin
        st_n     = TX_IDLE;
        done_set = 1'b1;
      end
      default: st_n = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= TX_IDLE;
      sr   <= '1;
      hold <= '0;
      pend <= 1'b0;
    end else begin
      st   <= st_n;
      sr   <= sr_n;
      hold <= hold_n;
      pend <= pend_n;
    end
  end

  assign busy    = pend || (st != TX_IDLE);
  assign drive   = (st == TX_SEND) || (st == TX_LAST);
  assign bit_out = sr[0];
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx
  import ssp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          at_s1p1,
  input  logic          at_s5p2,
  input  logic          at_s6p2,
  input  logic          start_ok,
  input  logic          din,
  output logic          busy,
  output logic          active,
  output logic [DW-1:0] byte_q,
  output logic          done_set
);
  localparam logic [DW-1:0] SEED = {{(DW-1){1'b1}}, 1'b0};

  rx_st_e        st, st_n;
  logic [DW-1:0] sr, sr_n, byte_n, shifted;
  logic          smp, smp_n;

  always_comb begin
    shifted = {sr[DW-2:0], smp};
  end

  always_comb begin
    st_n     = st;
    sr_n     = sr;
    smp_n    = smp;
    byte_n   = byte_q;
    done_set = 1'b0;
    case (st)
      RX_IDLE: if (start_ok && at_s6p2) st_n = RX_ARM;
      RX_ARM:  if (at_s6p2) begin
        sr_n = SEED;
        st_n = RX_LOAD;
      end
      RX_LOAD: if (at_s1p1) st_n = RX_RECV;
      RX_RECV: begin
        if (at_s5p2) smp_n = din;
        if (at_s6p2) begin
          sr_n = shifted;
          if (!sr[DW-1]) begin
            st_n = RX_LAST;
            for (int i = 0; i < DW; i++) byte_n[i] = shifted[DW-1-i];
          end
        end
      end
      RX_LAST: if (at_s1p1) begin
        st_n     = RX_IDLE;
        done_set = 1'b1;
      end
      default: st_n = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RX_IDLE;
      sr     <= '1;
      smp    <= 1'b1;
      byte_q <= '0;
    end else begin
      st     <= st_n;
      sr     <= sr_n;
      smp    <= smp_n;
      byte_q <= byte_n;
    end
  end

  assign busy   = (st != RX_IDLE);
  assign active = (st == RX_RECV) || (st == RX_LAST);
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_wr,
  input  logic [DATA_W-1:0] buf_wdata,
  input  logic              rx_en,
  input  logic              tx_clr,
  input  logic              rx_clr,
  input  logic              ser_din,
  output logic              ser_dout,
  output logic              ser_doe,
  output logic              shift_clk,
  output logic [DATA_W-1:0] rx_byte,
  output logic              tx_done,
  output logic              rx_done
);
  logic [1:0]       rst_sync;
  logic             rst_core_n;
  logic [CNT_W-1:0] slot_cnt;
  logic             at_s1p1, at_s5p2, at_s6p2, clk_low;
  logic             tx_busy, tx_drive, tx_bit, tx_set;
  logic             rx_busy, rx_active, rx_set;
  logic             wr_take, start_ok;
  logic             tx_done_n, rx_done_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  ssp_seq u_seq (
    .clk(clk), .rst_n(rst_core_n), .slot(slot_cnt),
    .at_s1p1(at_s1p1), .at_s5p2(at_s5p2), .at_s6p2(at_s6p2), .clk_low(clk_low)
  );

  assign wr_take  = buf_wr && !tx_busy && !rx_busy;
  assign start_ok = rx_en && !rx_done && !tx_busy && !buf_wr;

  ssp_tx #(.DW(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_core_n), .at_s1p1(at_s1p1), .at_s6p2(at_s6p2),
    .wr_take(wr_take), .wr_data(buf_wdata), .busy(tx_busy),
    .drive(tx_drive), .bit_out(tx_bit), .done_set(tx_set)
  );

  ssp_rx #(.DW(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_core_n), .at_s1p1(at_s1p1), .at_s5p2(at_s5p2),
    .at_s6p2(at_s6p2), .start_ok(start_ok), .din(ser_din), .busy(rx_busy),
    .active(rx_active), .byte_q(rx_byte), .done_set(rx_set)
  );

  always_comb begin
    tx_done_n = tx_set ? 1'b1 : (tx_clr ? 1'b0 : tx_done);
    rx_done_n = rx_set ? 1'b1 : (rx_clr ? 1'b0 : rx_done);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      tx_done <= 1'b0;
      rx_done <= 1'b0;
    end else begin
      tx_done <= tx_done_n;
      rx_done <= rx_done_n;
    end
  end

  assign ser_doe   = tx_drive;
  assign ser_dout  = tx_drive ? tx_bit : 1'b1;
  assign shift_clk = !((tx_drive || rx_active) && clk_low);
endmodule

// File: rtl/ssp_chk.sv
module ssp_chk
  import ssp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] slot,
  input logic             tx_busy,
  input logic             rx_busy,
  input logic             rx_active,
  input logic             ser_doe,
  input logic             shift_clk,
  input logic             tx_done,
  input logic             rx_done,
  input logic             tx_clr,
  input logic             rx_clr
);
  assert_cycle_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == CNT_W'(SLOTS - 1)) |=> (slot == '0));

  assert_idle_clk_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_doe && !rx_active) |-> shift_clk);

  assert_tx_done_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> (slot == CNT_W'(SL_S1P1 + 1)));

  assert_rx_done_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> (slot == CNT_W'(SL_S1P1 + 1)));

  assert_flag_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rx_busy) |=> !rx_busy);

  assert_one_direction_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_busy && rx_busy));

  assert_tx_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !tx_clr) |=> tx_done);

  assert_rx_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rx_clr) |=> rx_done);

  assert_no_drive_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_busy |-> !ser_doe);
endmodule

bind sync_shift_port ssp_chk u_chk (
  .clk(clk), .rst_n(rst_core_n), .slot(slot_cnt), .tx_busy(tx_busy),
  .rx_busy(rx_busy), .rx_active(rx_active), .ser_doe(ser_doe),
  .shift_clk(shift_clk), .tx_done(tx_done), .rx_done(rx_done),
  .tx_clr(tx_clr), .rx_clr(rx_clr)
);

// File: tb/tb_sync_shift_port.sv
module tb_sync_shift_port;
  localparam int CLK_P = 10;
  localparam int MC    = 12;

  typedef struct packed {
    logic       is_rx;
    logic [7:0] val;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 8'hA5}, '{1'b0, 8'h01}, '{1'b0, 8'h80},
    '{1'b1, 8'h5A}, '{1'b1, 8'hFF}, '{1'b1, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst_n, buf_wr, rx_en, tx_clr, rx_clr, ser_din;
  logic [7:0] buf_wdata, rx_byte;
  logic       ser_dout, ser_doe, shift_clk, tx_done, rx_done;

  int total = 0;
  int bad   = 0;
  int ck    = 0;
  int t0    = 0;

  always #(CLK_P / 2) clk = ~clk;
  always @(posedge clk) ck <= ck + 1;

  sync_shift_port dut (
    .clk(clk), .rst_n(rst_n), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
    .rx_en(rx_en), .tx_clr(tx_clr), .rx_clr(rx_clr), .ser_din(ser_din),
    .ser_dout(ser_dout), .ser_doe(ser_doe), .shift_clk(shift_clk),
    .rx_byte(rx_byte), .tx_done(tx_done), .rx_done(rx_done)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic at(input int pos);
    while ((ck - t0) < pos) @(negedge clk);
  endtask

  function automatic int next_base();
    return ((ck - t0) / MC + 1) * MC;
  endfunction

  task automatic run_tx(input logic [7:0] v, input int b, input bit full);
    at(b + 3); buf_wr = 1'b1; buf_wdata = v;
    at(b + 4); buf_wr = 1'b0;
    at(b + MC + 6);
    chk(ser_doe == 1'b0 && shift_clk == 1'b1, "R3 gap cycle idle", ser_doe, 0);
    for (int k = 0; k < 8; k++) begin
      if (full && k == 0) begin
        at(b + 2 * MC + 3); chk(shift_clk == 1'b1, "R1 clk high slot3", shift_clk, 1);
        at(b + 2 * MC + 4); chk(shift_clk == 1'b0, "R1 clk low slot4", shift_clk, 0);
        at(b + 2 * MC + 9); chk(shift_clk == 1'b0, "R1 clk low slot9", shift_clk, 0);
        at(b + 2 * MC + 10); chk(shift_clk == 1'b1, "R1 clk high slot10", shift_clk, 1);
      end
      at(b + (2 + k) * MC + 6);
      chk(ser_doe == 1'b1 && ser_dout == v[k], "R3 tx bit", {ser_doe, ser_dout}, {1'b1, v[k]});
    end
    at(b + 10 * MC);
    chk(tx_done == 1'b0, "R4 tx_done early", tx_done, 0);
    at(b + 10 * MC + 1);
    chk(tx_done == 1'b1 && ser_doe == 1'b0, "R4 tx_done on time", {tx_done, ser_doe}, 2);
  endtask

  task automatic clear_tx(input int b);
    at(b + 10 * MC + 2); tx_clr = 1'b1;
    at(b + 10 * MC + 3); tx_clr = 1'b0;
    chk(tx_done == 1'b0, "R9 tx clear", tx_done, 0);
  endtask

  task automatic run_rx(input logic [7:0] v, input int b);
    at(b + 3); rx_en = 1'b1;
    at(b + MC + 6);
    chk(shift_clk == 1'b1, "R5 no clock in cycle 1", shift_clk, 1);
    for (int k = 0; k < 8; k++) begin
      at(b + (2 + k) * MC + 6);
      ser_din = v[k];
      chk(shift_clk == 1'b0, "R5 rx shift clock", shift_clk, 0);
      chk(ser_doe == 1'b0, "R10 no drive in rx", ser_doe, 0);
    end
    at(b + 10 * MC);
    chk(rx_done == 1'b0, "R6 rx_done early", rx_done, 0);
    at(b + 10 * MC + 1);
    chk(rx_done == 1'b1, "R6 rx_done on time", rx_done, 1);
    chk(rx_byte == v, "R6 rx byte", rx_byte, v);
  endtask

  task automatic clear_rx(input int b);
    at(b + 10 * MC + 2); rx_en = 1'b0; rx_clr = 1'b1;
    at(b + 10 * MC + 3); rx_clr = 1'b0;
    chk(rx_done == 1'b0, "R9 rx clear", rx_done, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int b;
    rst_n = 1'b0; buf_wr = 1'b0; buf_wdata = '0; rx_en = 1'b0;
    tx_clr = 1'b0; rx_clr = 1'b0; ser_din = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    t0 = ck;

    at(1);
    chk(shift_clk && ser_dout && !ser_doe, "R2 reset lines", {shift_clk, ser_dout, ser_doe}, 3'b110);
    chk(!tx_done && !rx_done, "R2 reset flags", {tx_done, rx_done}, 0);

    foreach (VECS[i]) begin
      b = next_base();
      if (VECS[i].is_rx) begin
        run_rx(VECS[i].val, b); clear_rx(b);
      end else begin
        run_tx(VECS[i].val, b, i == 0); clear_tx(b);
      end
    end

    // R7 and R9: rx_done left set, rx_en held high
    b = next_base();
    run_rx(8'h96, b);
    for (int c = 11; c < 14; c++) begin
      at(b + c * MC + 6);
      chk(shift_clk == 1'b1, "R7 no restart while flag set", shift_clk, 1);
      chk(rx_done == 1'b1, "R9 rx flag holds", rx_done, 1);
    end
    at(b + 14 * MC + 2); rx_en = 1'b0; rx_clr = 1'b1;
    at(b + 14 * MC + 3); rx_clr = 1'b0;

    // R8: write during transmission ignored
    b = next_base();
    fork
      run_tx(8'hC3, b, 1'b0);
      begin
        at(b + 4 * MC + 3); buf_wr = 1'b1; buf_wdata = 8'h00;
        at(b + 4 * MC + 4); buf_wr = 1'b0;
      end
    join
    for (int c = 11; c < 14; c++) begin
      at(b + c * MC + 6);
      chk(ser_doe == 1'b0 && shift_clk == 1'b1, "R8 no second tx", ser_doe, 0);
      chk(tx_done == 1'b1, "R9 tx flag holds", tx_done, 1);
    end
    at(b + 14 * MC + 2); tx_clr = 1'b1;
    at(b + 14 * MC + 3); tx_clr = 1'b0;

    // R8: write during reception ignored
    b = next_base();
    fork
      run_rx(8'h3C, b);
      begin
        at(b + 3 * MC + 3); buf_wr = 1'b1; buf_wdata = 8'hFF;
        at(b + 3 * MC + 4); buf_wr = 1'b0;
      end
    join
    at(b + 10 * MC + 2); rx_en = 1'b0; rx_clr = 1'b1;
    at(b + 10 * MC + 3); rx_clr = 1'b0;
    for (int c = 11; c < 14; c++) begin
      at(b + c * MC + 6);
      chk(ser_doe == 1'b0 && shift_clk == 1'b1, "R8 write in rx ignored", ser_doe, 0);
    end
    chk(tx_done == 1'b0, "R8 no tx completion", tx_done, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule